// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Vector Unit

This unit holds the event flags of a master-mode I2C controller together with the interrupt-enable mask and the two DMA enables. From that state it drives three registered outputs. The first is a single interrupt line. The other two are DMA request lines, one for receive and one for transmit. The transfer logic raises flags through a set-pulse vector. Software reaches the state through a simple strobe-based register port: one select code, a write strobe, a read strobe and registered read data.

A build-time parameter chooses between two register layouts. In the older layout, software acknowledges events by reading an interrupt vector. That read returns the number of the lowest pending enabled flag and clears that flag. In the newer layout, the vector is absent and software clears flags by writing ones to the status register. The newer layout also offers a self-test write that raises all of the low status flags at once.

Top module: `i2c_irq_status_unit`

## Requirements
- R1: A synchronous active-high reset clears the status flags, the enable mask, the DMA enables, the read data and all three request outputs.
- R2: A set pulse on `set_flags_i` bit n holds status bit n until it is cleared. The flag positions are: bit 1 no-acknowledge, bit 2 access-ready, bit 3 receive-ready, bit 4 transmit-ready, bit 10 transmit underflow, bit 11 receive overrun, bit 15 single-byte data. Bit 12 is never stored.
- R3: `irq_o` is high, one clock after the state changes, exactly when status AND enable mask is nonzero.
- R4: Reading select 0 (status) returns the stored flags with bit 12 replaced by `bus_busy_i` as sampled at the read.
- R5: Writing select 1 (enable) keeps bits 4:0 in the older layout and bits 5:0 in the newer layout. All other bits read back as zero.
- R6: Writing select 2 (DMA) keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). Writing a one to bit 15 clears enable bit 3, and writing a one to bit 7 clears enable bit 4.
- R7: `rx_dma_req_o` equals status bit 3 while receive DMA is enabled and is low otherwise. `tx_dma_req_o` does the same with status bit 4 and transmit DMA.
- R8: In the older layout, reading select 3 (vector) returns the 1-based position of the lowest set bit of status AND mask, and clears that status bit.
- R9: In the older layout, a vector read with nothing pending returns 0, and writes to the status register have no effect.
- R10: In the newer layout, writing the status register clears only those written-one bits that lie inside 0x0027. A vector read returns 0 and clears nothing.
- R11: In the newer layout, writing select 4 (self-test) with bit 11 set sets status bits 5:0. In the older layout, such a write has no effect.
- R12: When a set pulse and a clear (a status write or a vector read) hit the same flag in the same cycle, the flag ends up set.
- R13: Read data is registered. It appears after the clock edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 3 | Register select: 0 status, 1 enable, 2 DMA, 3 vector, 4 self-test |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| set_flags_i | input | 16 | One-cycle set pulses from the transfer logic |
| bus_busy_i | input | 1 | Bus-busy level shown in status bit 12 |
| irq_o | output | 1 | Combined interrupt request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |

## Verification
Two functions can land in the same cycle: a set pulse from the transfer logic, and a software clear of the same flag. In the newer layout the clear is a write-one-to-clear; in the older layout it is a vector read. The bench drives the set pulse and the clearing access in one cycle on both layouts. It then reads the status, or reads the vector a second time, to confirm that the flag survived. The vector read in that cycle must still report the flag's index. A DMA-enable write arriving together with a pending receive flag is also covered: the interrupt must drop at the same edge at which the DMA request rises.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int unsigned DW = 16;
    localparam int unsigned IDX_W = $clog2(DW + 1);

    // register select codes
    localparam logic [2:0] SEL_STAT = 3'd0;
    localparam logic [2:0] SEL_ENA  = 3'd1;
    localparam logic [2:0] SEL_DMA  = 3'd2;
    localparam logic [2:0] SEL_VEC  = 3'd3;
    localparam logic [2:0] SEL_TEST = 3'd4;

    // flag positions
    localparam int unsigned FLG_NACK = 1;
    localparam int unsigned FLG_ARDY = 2;
    localparam int unsigned FLG_RRDY = 3;
    localparam int unsigned FLG_XRDY = 4;
    localparam int unsigned FLG_XUDF = 10;
    localparam int unsigned FLG_ROVR = 11;
    localparam int unsigned FLG_BUSY = 12;
    localparam int unsigned FLG_SBD  = 15;

    localparam int unsigned DMA_RX_BIT = 15;
    localparam int unsigned DMA_TX_BIT = 7;
    localparam int unsigned TEST_FORCE_BIT = 11;

    localparam logic [DW-1:0] STORE_MASK = ~(DW'(1) << FLG_BUSY);
    localparam logic [DW-1:0] DMA_KEEP   = (DW'(1) << DMA_RX_BIT) | (DW'(1) << DMA_TX_BIT);
    localparam logic [DW-1:0] W1C_MASK   = DW'(16'h0027);
    localparam logic [DW-1:0] TEST_FORCE = DW'(16'h003F);
    localparam logic [DW-1:0] ENA_OLD    = DW'(16'h001F);
    localparam logic [DW-1:0] ENA_NEW    = DW'(16'h003F);

    typedef struct packed {
        logic [DW-1:0] status;
        logic [DW-1:0] mask;
        logic [DW-1:0] dma;
        logic [DW-1:0] rdata;
        logic          irq;
        logic          rx_req;
        logic          tx_req;
    } unit_state_t;

endpackage

// File: rtl/i2c_irq_vec_enc.sv
module i2c_irq_vec_enc #(
    parameter int unsigned W = 16,
    localparam int unsigned OUT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     pend_i,
    output logic [OUT_W-1:0] idx_o,
    output logic [W-1:0]     onehot_o
);
    // lowest set bit wins; scanned from the top so the last hit is the lowest
    always_comb begin
        idx_o    = '0;
        onehot_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o       = OUT_W'(i + 1);
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_irq_next.sv
module i2c_irq_next
    import i2c_irq_pkg::*;
#(
    parameter bit NEW_LAYOUT = 1'b1
) (
    input  unit_state_t   cur_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [2:0]    sel_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] set_i,
    input  logic          busy_i,
    output unit_state_t   nxt_o
);
    localparam logic [DW-1:0] ENA_KEEP = NEW_LAYOUT ? ENA_NEW : ENA_OLD;

    logic [DW-1:0]    pend;
    logic [IDX_W-1:0] vec_idx;
    logic [DW-1:0]    vec_onehot;
    logic [DW-1:0]    clr_w;
    logic [DW-1:0]    force_w;
    logic [DW-1:0]    vec_rd_w;

    assign pend = cur_i.status & cur_i.mask;

    i2c_irq_vec_enc #(.W(DW)) u_vec (
        .pend_i   (pend),
        .idx_o    (vec_idx),
        .onehot_o (vec_onehot)
    );

    generate
        if (NEW_LAYOUT) begin : g_new
            assign clr_w    = (wr_i && sel_i == SEL_STAT) ? (wdata_i & W1C_MASK) : '0;
            assign force_w  = (wr_i && sel_i == SEL_TEST && wdata_i[TEST_FORCE_BIT]) ? TEST_FORCE : '0;
            assign vec_rd_w = '0;
        end else begin : g_old
            assign clr_w    = (rd_i && sel_i == SEL_VEC) ? vec_onehot : '0;
            assign force_w  = '0;
            assign vec_rd_w = DW'(vec_idx);
        end
    endgenerate

    always_comb begin
        nxt_o = cur_i;

        // set has priority over clear
        nxt_o.status = ((cur_i.status & ~clr_w) | set_i | force_w) & STORE_MASK;

        if (wr_i && sel_i == SEL_ENA) begin
            nxt_o.mask = wdata_i & ENA_KEEP;
        end
        if (wr_i && sel_i == SEL_DMA) begin
            nxt_o.dma = wdata_i & DMA_KEEP;
            if (wdata_i[DMA_RX_BIT]) nxt_o.mask[FLG_RRDY] = 1'b0;
            if (wdata_i[DMA_TX_BIT]) nxt_o.mask[FLG_XRDY] = 1'b0;
        end

        nxt_o.irq    = |(nxt_o.status & nxt_o.mask);
        nxt_o.rx_req = nxt_o.dma[DMA_RX_BIT] & nxt_o.status[FLG_RRDY];
        nxt_o.tx_req = nxt_o.dma[DMA_TX_BIT] & nxt_o.status[FLG_XRDY];

        if (rd_i) begin
            case (sel_i)
                SEL_STAT: begin
                    nxt_o.rdata           = cur_i.status;
                    nxt_o.rdata[FLG_BUSY] = busy_i;
                end
                SEL_ENA: nxt_o.rdata = cur_i.mask;
                SEL_DMA: nxt_o.rdata = cur_i.dma;
                SEL_VEC: nxt_o.rdata = vec_rd_w;
                default: nxt_o.rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/i2c_irq_status_unit.sv
module i2c_irq_status_unit
    import i2c_irq_pkg::*;
#(
    parameter bit NEW_LAYOUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_i,
    input  logic        reg_rd_i,
    input  logic [2:0]  reg_sel_i,
    input  logic [15:0] reg_wdata_i,
    output logic [15:0] reg_rdata_o,
    input  logic [15:0] set_flags_i,
    input  logic        bus_busy_i,
    output logic        irq_o,
    output logic        rx_dma_req_o,
    output logic        tx_dma_req_o
);
    localparam logic [DW-1:0] ENA_KEEP = NEW_LAYOUT ? ENA_NEW : ENA_OLD;

    unit_state_t state_d, state_q;

    i2c_irq_next #(.NEW_LAYOUT(NEW_LAYOUT)) u_next (
        .cur_i   (state_q),
        .wr_i    (reg_wr_i),
        .rd_i    (reg_rd_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .set_i   (set_flags_i),
        .busy_i  (bus_busy_i),
        .nxt_o   (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign reg_rdata_o  = state_q.rdata;
    assign irq_o        = state_q.irq;
    assign rx_dma_req_o = state_q.rx_req;
    assign tx_dma_req_o = state_q.tx_req;

    // R3
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ((|(set_flags_i & state_q.mask)) && !(reg_wr_i && (reg_sel_i == SEL_ENA || reg_sel_i == SEL_DMA)))
        |=> irq_o);

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_flags_i) |=> ((state_q.status & $past(set_flags_i & STORE_MASK)) == $past(set_flags_i & STORE_MASK)));

    // R6
    dma_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_sel_i == SEL_DMA && reg_wdata_i[DMA_RX_BIT]) |=> !state_q.mask[FLG_RRDY]);

    // R7
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !state_q.dma[DMA_RX_BIT] |-> !rx_dma_req_o);

    // R5
    mask_width_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_sel_i == SEL_ENA) |=> ((state_q.mask & ~ENA_KEEP) == '0));

    generate
        if (NEW_LAYOUT) begin : g_chk_new
            // R10
            vec_absent_chk: assert property (@(posedge clk) disable iff (rst)
                (reg_rd_i && reg_sel_i == SEL_VEC) |=> (reg_rdata_o == '0));
        end else begin : g_chk_old
            // R8
            vec_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
                (reg_rd_i && reg_sel_i == SEL_VEC && (|(state_q.status & state_q.mask)))
                |=> (reg_rdata_o != '0));
        end
    endgenerate
endmodule

// File: tb/i2c_irq_status_unit_tb_top.sv
module i2c_irq_status_unit_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    // newer-layout instance
    logic        n_wr = 0, n_rd = 0, n_busy = 0;
    logic [2:0]  n_sel = 0;
    logic [15:0] n_wd = 0, n_set = 0, n_rdata;
    logic        n_irq, n_rx, n_tx;
    // older-layout instance
    logic        o_wr = 0, o_rd = 0, o_busy = 0;
    logic [2:0]  o_sel = 0;
    logic [15:0] o_wd = 0, o_set = 0, o_rdata;
    logic        o_irq, o_rx, o_tx;

    i2c_irq_status_unit #(.NEW_LAYOUT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .reg_wr_i(n_wr), .reg_rd_i(n_rd), .reg_sel_i(n_sel),
        .reg_wdata_i(n_wd), .reg_rdata_o(n_rdata), .set_flags_i(n_set),
        .bus_busy_i(n_busy), .irq_o(n_irq), .rx_dma_req_o(n_rx), .tx_dma_req_o(n_tx));

    i2c_irq_status_unit #(.NEW_LAYOUT(1'b0)) dut_old_i (
        .clk(clk), .rst(rst), .reg_wr_i(o_wr), .reg_rd_i(o_rd), .reg_sel_i(o_sel),
        .reg_wdata_i(o_wd), .reg_rdata_o(o_rdata), .set_flags_i(o_set),
        .bus_busy_i(o_busy), .irq_o(o_irq), .rx_dma_req_o(o_rx), .tx_dma_req_o(o_tx));

    int n_checks = 0;
    int n_fails  = 0;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    // op: 0 idle, 1 write, 2 read
    task automatic cyc_new(input int op, input logic [2:0] sel, input logic [15:0] wd, input logic [15:0] set);
        @(negedge clk);
        n_wr = (op == 1); n_rd = (op == 2); n_sel = sel; n_wd = wd; n_set = set;
        @(negedge clk);
        n_wr = 0; n_rd = 0; n_set = 0;
    endtask

    task automatic cyc_old(input int op, input logic [2:0] sel, input logic [15:0] wd, input logic [15:0] set);
        @(negedge clk);
        o_wr = (op == 1); o_rd = (op == 2); o_sel = sel; o_wd = wd; o_set = set;
        @(negedge clk);
        o_wr = 0; o_rd = 0; o_set = 0;
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  sel;
        logic [15:0] wd;
        logic [15:0] set;
        logic        irq;
        logic        rx;
        logic        tx;
        logic [15:0] rd;
        logic [3:0]  req;
    } vec_t;

    // sel: 0 status, 1 enable, 2 DMA, 3 vector, 4 self-test (newer layout)
    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 3'd1, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd5},  // R5
        '{2'd2, 3'd1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h003F, 4'd5},  // R5
        '{2'd0, 3'd0, 16'h0000, 16'h0008, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd3},  // R3
        '{2'd2, 3'd0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0008, 4'd4},  // R4
        '{2'd1, 3'd2, 16'h8080, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 4'd7},  // R7
        '{2'd2, 3'd2, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h8080, 4'd6},  // R6
        '{2'd2, 3'd1, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0027, 4'd6},  // R6
        '{2'd0, 3'd0, 16'h0000, 16'h0010, 1'b0, 1'b1, 1'b1, 16'h0000, 4'd7},  // R7
        '{2'd1, 3'd0, 16'h0018, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0000, 4'd10}, // R10
        '{2'd0, 3'd0, 16'h0000, 16'h0C02, 1'b1, 1'b1, 1'b1, 16'h0000, 4'd2},  // R2
        '{2'd1, 3'd0, 16'h0002, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0000, 4'd10}, // R10
        '{2'd2, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0C18, 4'd2},  // R2
        '{2'd2, 3'd3, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0000, 4'd10}, // R10
        '{2'd2, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0C18, 4'd10}, // R10
        '{2'd1, 3'd2, 16'h7F7F, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd7},  // R7
        '{2'd2, 3'd2, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6
        '{2'd1, 3'd4, 16'h0800, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd11}, // R11
        '{2'd2, 3'd0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0C3F, 4'd11}, // R11
        '{2'd1, 3'd0, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd10}, // R10
        '{2'd2, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0C18, 4'd10}  // R10
    };

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1", {13'd0, n_irq, n_rx, n_tx}, 16'h0);
        chk("R1", {13'd0, o_irq, o_rx, o_tx}, 16'h0);
        chk("R1", n_rdata, 16'h0);
        cyc_new(2, 3'd0, 16'h0, 16'h0); chk("R1", n_rdata, 16'h0);
        cyc_new(2, 3'd1, 16'h0, 16'h0); chk("R1", n_rdata, 16'h0);
        cyc_new(2, 3'd2, 16'h0, 16'h0); chk("R1", n_rdata, 16'h0);

        // vector table on the newer layout
        for (int k = 0; k < NV; k++) begin
            cyc_new(int'(TBL[k].op), TBL[k].sel, TBL[k].wd, TBL[k].set);
            tag = $sformatf("R%0d step %0d", TBL[k].req, k);
            chk({tag, " irq"}, {15'd0, n_irq}, {15'd0, TBL[k].irq});
            chk({tag, " rx"},  {15'd0, n_rx},  {15'd0, TBL[k].rx});
            chk({tag, " tx"},  {15'd0, n_tx},  {15'd0, TBL[k].tx});
            if (TBL[k].op == 2'd2) chk({tag, " rdata"}, n_rdata, TBL[k].rd);
        end

        // R4 busy level replaces bit 12
        n_busy = 1;
        cyc_new(2, 3'd0, 16'h0, 16'h0); chk("R4 busy", n_rdata, 16'h1C18);
        n_busy = 0;
        // R2 bit 12 is not stored
        cyc_new(0, 3'd0, 16'h0, 16'h1000);
        cyc_new(2, 3'd0, 16'h0, 16'h0); chk("R2 bit12", n_rdata, 16'h0C18);
        // R12 set beats write-one-to-clear
        cyc_new(1, 3'd0, 16'h0002, 16'h0002);
        chk("R12 irq", {15'd0, n_irq}, 16'h1);
        cyc_new(2, 3'd0, 16'h0, 16'h0); chk("R12 new", n_rdata, 16'h0C1A);
        // R13 read data holds
        cyc_new(0, 3'd0, 16'h0, 16'h0); chk("R13 hold", n_rdata, 16'h0C1A);
        @(negedge clk);
        n_rd = 1; n_sel = 3'd1;
        #1 chk("R13 before edge", n_rdata, 16'h0C1A);
        @(negedge clk);
        n_rd = 0;
        chk("R13 after edge", n_rdata, 16'h0027);

        // older layout
        cyc_old(1, 3'd1, 16'hFFFF, 16'h0);
        cyc_old(2, 3'd1, 16'h0, 16'h0); chk("R5 old", o_rdata, 16'h001F);
        cyc_old(0, 3'd0, 16'h0, 16'h001A);
        chk("R3 old", {15'd0, o_irq}, 16'h1);
        cyc_old(2, 3'd3, 16'h0, 16'h0); chk("R8 first", o_rdata, 16'd2);
        cyc_old(2, 3'd3, 16'h0, 16'h0); chk("R8 second", o_rdata, 16'd4);
        cyc_old(2, 3'd3, 16'h0, 16'h0); chk("R8 third", o_rdata, 16'd5);
        chk("R8 irq low", {15'd0, o_irq}, 16'h0);
        cyc_old(2, 3'd3, 16'h0, 16'h0); chk("R9 empty", o_rdata, 16'd0);
        cyc_old(0, 3'd0, 16'h0, 16'h0002);
        cyc_old(1, 3'd0, 16'hFFFF, 16'h0);
        cyc_old(2, 3'd0, 16'h0, 16'h0); chk("R9 write ignored", o_rdata, 16'h0002);
        cyc_old(1, 3'd4, 16'h0800, 16'h0);
        cyc_old(2, 3'd0, 16'h0, 16'h0); chk("R11 old ignored", o_rdata, 16'h0002);
        cyc_old(2, 3'd3, 16'h0, 16'h0002); chk("R12 old vec", o_rdata, 16'd2);
        cyc_old(2, 3'd0, 16'h0, 16'h0); chk("R12 old", o_rdata, 16'h0002);

        finish_run();
    end
endmodule